// File: doc/BRIEF.md
# Doorbell Completion Filter with Interrupts

This block is the control and status unit for outbound doorbell messages. Each response that comes back for an outbound doorbell is presented on a one-cycle event input with its payload, destination identifier and an outcome code. Two control bits decide, separately for successful responses and for failed or timed-out ones, whether the response is queued in a 16-entry completion queue or silently discarded. Software drains the queue through a register port. It first peeks the head entry's outcome and valid flag, then reads the data word, which pops the entry.

The block also counts each received-doorbell pulse as an event. It keeps three write-one-to-clear status bits: doorbell received, completion queued, and completion queue overflow. Each bit has its own enable. The block drives one registered interrupt line. The overflow bit is sticky: a clear is refused until software has popped at least one queue entry after the overflow happened.

Top module: `dbell_cpl_ctrl`

## Requirements
- R1: After reset every register reads 0, the queue is empty (offset 0x2C reads 0) and `irq` is 0.
- R2: Offset 0x1C holds two read/write control bits [1:0], offset 0x20 holds three read/write enable bits [2:0], and offset 0x24 holds the status. All other bits of these three registers read 0 and ignore writes, and an unmapped offset reads 0.
- R3: A response with outcome code 00 (success) is queued only when control bit 0 is set. Otherwise it is dropped and no status bit changes.
- R4: A response with outcome code 01 (error), 10 (timeout) or 11 (treated as failure) is queued only when control bit 1 is set. Otherwise it is dropped and no status bit changes.
- R5: The queue holds 16 entries in arrival order. A read of 0x2C returns the head without popping: bit 31 is the valid flag and bits [1:0] are the outcome code. A read of 0x28 returns {destination[31:16], payload[15:0]} of the head and pops it.
- R6: A read of 0x28 or 0x2C while the queue is empty returns 0 and removes nothing.
- R7: A response that passes the filter while 16 entries are held is dropped and sets status bit 2 (overflow). It does not set bit 1.
- R8: Status bit 1 sets whenever an entry is queued, and status bit 0 sets on each `rx_dbell` pulse. Writing 1 to a status bit at 0x24 clears it, and writing 0 leaves it unchanged.
- R9: Status bit 2 ignores a write-1 clear until at least one entry has been popped since the overflow was recorded. After such a pop the clear works, even if the queue is not empty.
- R10: When a hardware set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is the OR over the three bits of (status AND enable). It is registered, so it follows a change of status or enable one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe; data appears on `reg_rdata` after the next edge |
| reg_rdata | output | 32 | Registered read data |
| rsp_valid | input | 1 | One-cycle outbound doorbell response event |
| rsp_outcome | input | 2 | Outcome code: 00 success, 01 error, 10 timeout |
| rsp_payload | input | 16 | Doorbell payload of the response |
| rsp_dest | input | 16 | Destination identifier of the response |
| rx_dbell | input | 1 | One-cycle pulse per received doorbell |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of the two control bits against every outcome code. A filter that swaps the two classes, or that mishandles the reserved code, would queue an entry where none is due, or lose one that is due. It fills the queue to exactly 16 entries and then sends one more. A design with an off-by-one capacity would either raise overflow one entry early or keep the seventeenth entry, and the drain in arrival order would expose either mistake. It tries to clear overflow before any pop: a design without the pop gate would drop the bit at once. It also fires a received pulse in the same cycle as its clear, where a design with the wrong priority would lose the event.

// File: rtl/dbc_pkg.sv
// Package: shared types and constants for the doorbell completion filter.
// Assumes a 32-bit register data path and 16-bit payload and destination fields.
package dbc_pkg;
    localparam int DATA_W    = 32;
    localparam int PAYLOAD_W = 16;
    localparam int DEST_W    = 16;
    localparam int NSTAT     = 3;

    // Status and enable bit positions
    localparam int ST_RX  = 0;
    localparam int ST_TXC = 1;
    localparam int ST_OVF = 2;

    typedef enum logic [1:0] {
        OUT_OK  = 2'b00,
        OUT_ERR = 2'b01,
        OUT_TMO = 2'b10,
        OUT_RSV = 2'b11
    } outcome_e;

    typedef struct packed {
        logic [DEST_W-1:0]    dest;
        logic [PAYLOAD_W-1:0] payload;
        outcome_e             outcome;
    } cpl_entry_t;
endpackage

// File: rtl/dbc_filter.sv
// Module: dbc_filter
// Decides, for each response event, whether to queue it, drop it silently,
// or record an overflow. Purely combinational.
// Assumes the queue's full flag reflects the current cycle's occupancy.
module dbc_filter
    import dbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rsp_valid,
    input  outcome_e outcome,
    input  logic     keep_ok,
    input  logic     keep_fail,
    input  logic     q_full,
    output logic     push,
    output logic     overflow
);
    logic accept;

    // Pick the enable that matches the outcome class, then route on fullness
    always_comb begin
        if (outcome == OUT_OK) accept = rsp_valid && keep_ok;
        else                   accept = rsp_valid && keep_fail;
        push     = accept && !q_full;
        overflow = accept && q_full;
    end

    // R3: success responses are dropped when the success enable is clear
    assert_drop_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && outcome == OUT_OK && !keep_ok) |-> (!push && !overflow));

    // R4: failed responses are dropped when the failure enable is clear
    assert_drop_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && outcome != OUT_OK && !keep_fail) |-> (!push && !overflow));

    // R7: the queue and the overflow report never both take one response
    assert_push_xor_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && overflow));
endmodule

// File: rtl/dbc_cpl_fifo.sv
// Module: dbc_cpl_fifo
// Completion queue with show-ahead head output and occupancy tracking.
// Assumes the caller never pushes while full and never pops while empty.
// A push that arrives while full is refused.
module dbc_cpl_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 34
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP   = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    // Gate the requests against the occupancy flags
    always_comb begin
        empty   = (count == '0);
        full    = (count == CAP);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Storage write; data needs no reset
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // R7: occupancy never passes the capacity
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

    // R7: the caller does not push into a full queue
    assert_push_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6: a pop on an empty queue leaves it empty
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/dbc_irq_unit.sv
// Module: dbc_irq_unit
// Keeps the three write-one-to-clear status bits and drives the registered
// interrupt. A set event beats a clear on the same bit. The overflow clear
// is armed only by a queue pop seen after the overflow was recorded.
module dbc_irq_unit
    import dbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSTAT-1:0] set_evt,
    input  logic             clr_wr,
    input  logic [NSTAT-1:0] clr_bits,
    input  logic             pop_evt,
    input  logic [NSTAT-1:0] irq_en,
    output logic [NSTAT-1:0] status,
    output logic             irq
);
    logic [NSTAT-1:0] status_q, clr_eff, status_d;
    logic             ovf_armed;

    // Clear mask after the overflow gate, and next status with set priority
    always_comb begin
        clr_eff = clr_wr ? clr_bits : '0;
        if (!ovf_armed) clr_eff[ST_OVF] = 1'b0;
        for (int i = 0; i < NSTAT; i++) begin
            status_d[i] = set_evt[i] | (status_q[i] & ~clr_eff[i]);
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Overflow clear arming: a new overflow disarms, a later pop arms
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_armed <= 1'b0;
        else if (set_evt[ST_OVF])  ovf_armed <= 1'b0;
        else if (pop_evt)          ovf_armed <= 1'b1;
    end

    // Registered interrupt output
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_q & irq_en);
    end

    assign status = status_q;

    // R10: every set event leaves its bit set in the next cycle
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[ST_RX] |=> status_q[ST_RX]);

    // R9: overflow stays set while no pop has armed its clear
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[ST_OVF] && !ovf_armed && !pop_evt) |=> status_q[ST_OVF]);

    // R11: with every enable clear the interrupt is low one cycle later
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |=> !irq);
endmodule

// File: rtl/dbell_cpl_ctrl.sv
// Module: dbell_cpl_ctrl (top)
// Register-mapped control and status for outbound doorbell completions:
// filter, completion queue, W1C status and interrupt. Reads are registered:
// data appears one cycle after the read strobe. A read of the data offset
// pops the queue head.
module dbell_cpl_ctrl
    import dbc_pkg::*;
#(
    parameter int                  ADDR_W   = 8,
    parameter int                  DEPTH    = 16,
    parameter logic [ADDR_W-1:0]   CTL_OFS  = 8'h1C,
    parameter logic [ADDR_W-1:0]   IEN_OFS  = 8'h20,
    parameter logic [ADDR_W-1:0]   STA_OFS  = 8'h24,
    parameter logic [ADDR_W-1:0]   DAT_OFS  = 8'h28,
    parameter logic [ADDR_W-1:0]   PEEK_OFS = 8'h2C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_rd,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 rsp_valid,
    input  logic [1:0]           rsp_outcome,
    input  logic [PAYLOAD_W-1:0] rsp_payload,
    input  logic [DEST_W-1:0]    rsp_dest,
    input  logic                 rx_dbell,
    output logic                 irq
);
    localparam int ENT_W = $bits(cpl_entry_t);

    logic [1:0]        ctl_q;
    logic [NSTAT-1:0]  ien_q;
    logic [NSTAT-1:0]  status;
    logic [DATA_W-1:0] rdata_q;
    logic              q_push, q_ovf, q_pop, q_empty, q_full;
    cpl_entry_t        in_ent, head_ent;
    logic [ENT_W-1:0]  head_raw;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSTAT];

    // Pack the incoming response into a queue entry
    always_comb begin
        in_ent.dest    = rsp_dest;
        in_ent.payload = rsp_payload;
        in_ent.outcome = outcome_e'(rsp_outcome);
        head_ent       = cpl_entry_t'(head_raw);
        q_pop          = reg_rd && (reg_addr == DAT_OFS) && !q_empty;
    end

    dbc_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .outcome   (outcome_e'(rsp_outcome)),
        .keep_ok   (ctl_q[0]),
        .keep_fail (ctl_q[1]),
        .q_full    (q_full),
        .push      (q_push),
        .overflow  (q_ovf)
    );

    dbc_cpl_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (in_ent),
        .pop   (q_pop),
        .dout  (head_raw),
        .empty (q_empty),
        .full  (q_full)
    );

    dbc_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  ({q_ovf, q_push, rx_dbell}),
        .clr_wr   (reg_wr && (reg_addr == STA_OFS)),
        .clr_bits (reg_wdata[NSTAT-1:0]),
        .pop_evt  (q_pop),
        .irq_en   (ien_q),
        .status   (status),
        .irq      (irq)
    );

    // Control and enable registers; reserved bits are not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ien_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == CTL_OFS) ctl_q <= reg_wdata[1:0];
            if (reg_addr == IEN_OFS) ien_q <= reg_wdata[NSTAT-1:0];
        end
    end

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                CTL_OFS:  rdata_q <= {{(DATA_W-2){1'b0}}, ctl_q};
                IEN_OFS:  rdata_q <= {{(DATA_W-NSTAT){1'b0}}, ien_q};
                STA_OFS:  rdata_q <= {{(DATA_W-NSTAT){1'b0}}, status};
                DAT_OFS:  rdata_q <= q_empty ? '0 : {head_ent.dest, head_ent.payload};
                PEEK_OFS: rdata_q <= q_empty ? '0 :
                                     {1'b1, {(DATA_W-3){1'b0}}, head_ent.outcome};
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;

    // R6: a data read of an empty queue returns zero
    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == DAT_OFS && q_empty) |=> (reg_rdata == '0));

    // R2: reserved control bits always read as zero
    assert_ctl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == CTL_OFS) |=> (reg_rdata[DATA_W-1:2] == '0));
endmodule

// File: tb/dbell_cpl_ctrl_bench.sv
module dbell_cpl_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        rsp_valid = 1'b0;
    logic [1:0]  rsp_outcome = '0;
    logic [15:0] rsp_payload = '0;
    logic [15:0] rsp_dest = '0;
    logic        rx_dbell = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_CTL = 8'h1C, A_IEN = 8'h20, A_STA = 8'h24,
                           A_DAT = 8'h28, A_PEEK = 8'h2C;

    always #5 clk = ~clk;

    dbell_cpl_ctrl u_dbell_cpl_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_payload(rsp_payload), .rsp_dest(rsp_dest),
        .rx_dbell(rx_dbell), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic send(input logic [1:0] code, input logic [15:0] pl, input logic [15:0] ds);
        @(negedge clk); rsp_valid = 1'b1; rsp_outcome = code; rsp_payload = pl; rsp_dest = ds;
        @(negedge clk); rsp_valid = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk); rx_dbell = 1'b1;
        @(negedge clk); rx_dbell = 1'b0;
    endtask

    function automatic logic [15:0] fill_pl(input int i);
        return 16'hA000 + 16'(i * 37);
    endfunction
    function automatic logic [15:0] fill_ds(input int i);
        return 16'h0100 * 16'(i) + 16'h0005;
    endfunction

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd(A_CTL, v);  chk("R1 ctl", v, 0);
        rd(A_IEN, v);  chk("R1 ien", v, 0);
        rd(A_STA, v);  chk("R1 status", v, 0);
        rd(A_PEEK, v); chk("R1 queue empty", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2: reserved bits and unmapped offsets
        wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); chk("R2 ctl mask", v, 32'h3);
        wr(A_IEN, 32'hFFFF_FFF8); rd(A_IEN, v); chk("R2 ien reserved", v, 32'h0);
        wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, v); chk("R2 ien mask", v, 32'h7);
        wr(A_STA, 32'hFFFF_FFFF); rd(A_STA, v); chk("R2 status reserved", v, 32'h0);
        rd(8'h30, v); chk("R2 unmapped", v, 0);
        wr(A_IEN, 0); wr(A_CTL, 0);

        // R3/R4: sweep enables against every outcome code
        for (int en = 0; en < 4; en++) begin
            for (int code = 0; code < 4; code++) begin
                logic pass;
                logic [15:0] pl, ds;
                pl = 16'h1000 + 16'(en * 4 + code);
                ds = 16'h2000 + 16'(code * 16 + en);
                pass = (code == 0) ? en[0] : en[1];
                wr(A_CTL, 32'(en));
                send(2'(code), pl, ds);
                rd(A_STA, v);
                chk(code == 0 ? "R3 status txc" : "R4 status txc", v, pass ? 32'h2 : 32'h0);
                rd(A_PEEK, v);
                chk(code == 0 ? "R3 peek" : "R4 peek", v,
                    pass ? (32'h8000_0000 | 32'(code)) : 32'h0);
                rd(A_DAT, v);
                chk(code == 0 ? "R3 data" : "R4 data", v, pass ? {ds, pl} : 32'h0);
                wr(A_STA, 32'h2);
                rd(A_STA, v); chk("R8 txc cleared", v, 0);
            end
        end

        // R8: received pulse sets bit 0, write 0 keeps it, write 1 clears it
        pulse_rx();
        rd(A_STA, v); chk("R8 rx set", v, 32'h1);
        wr(A_STA, 32'h0); rd(A_STA, v); chk("R8 write0 keeps", v, 32'h1);
        wr(A_STA, 32'h1); rd(A_STA, v); chk("R8 rx cleared", v, 32'h0);

        // R10: set and clear in the same cycle
        @(negedge clk); rx_dbell = 1'b1; reg_addr = A_STA; reg_wdata = 32'h1; reg_wr = 1'b1;
        @(negedge clk); rx_dbell = 1'b0; reg_wr = 1'b0;
        rd(A_STA, v); chk("R10 set wins", v, 32'h1);
        wr(A_STA, 32'h1);

        // R7: fill to capacity, then one more
        wr(A_CTL, 32'h3);
        for (int i = 0; i < 16; i++) send(2'(i % 3), fill_pl(i), fill_ds(i));
        rd(A_STA, v); chk("R7 full no overflow", v, 32'h2);
        wr(A_STA, 32'h2);
        send(2'b00, 16'hDEAD, 16'hBEEF);
        rd(A_STA, v); chk("R7 overflow set", v, 32'h4);

        // R9: clear refused before any pop
        wr(A_STA, 32'h4); rd(A_STA, v); chk("R9 sticky before pop", v, 32'h4);

        // R5: drain in arrival order
        for (int i = 0; i < 16; i++) begin
            rd(A_PEEK, v); chk("R5 peek", v, 32'h8000_0000 | 32'(i % 3));
            rd(A_DAT, v);  chk("R5 data", v, {fill_ds(i), fill_pl(i)});
        end
        // R6: empty reads
        rd(A_DAT, v);  chk("R6 empty data", v, 0);
        rd(A_PEEK, v); chk("R6 empty peek", v, 0);
        wr(A_STA, 32'h4); rd(A_STA, v); chk("R9 cleared after pop", v, 0);

        // R9: clear works after one pop without draining
        for (int i = 0; i < 17; i++) send(2'b01, fill_pl(i), fill_ds(i));
        rd(A_DAT, v); chk("R9 first entry", v, {fill_ds(0), fill_pl(0)});
        wr(A_STA, 32'h4); rd(A_STA, v); chk("R9 partial drain clear", v, 32'h2);
        send(2'b10, 16'h7777, 16'h8888);   // refills to 16 entries
        send(2'b10, 16'h7778, 16'h8889);   // overflows again
        pulse_rx();
        rd(A_STA, v); chk("R8 all set", v, 32'h7);

        // R11: latency, then enable sweep
        @(negedge clk); chk("R11 idle irq", {31'b0, irq}, 0);
        wr(A_IEN, 32'h1);
        chk("R11 irq lags", {31'b0, irq}, 0);
        @(negedge clk); chk("R11 irq after lag", {31'b0, irq}, 1);
        for (int en = 0; en < 8; en++) begin
            wr(A_IEN, 32'(en)); @(negedge clk);
            chk("R11 sweep all set", {31'b0, irq}, {31'b0, en != 0});
        end
        wr(A_STA, 32'h3);
        for (int en = 0; en < 8; en++) begin
            wr(A_IEN, 32'(en)); @(negedge clk);
            chk("R11 sweep ovf only", {31'b0, irq}, {31'b0, en[2]});
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule